// File: doc/BRIEF.md
# Inner-Level Stack Pointer Fetcher

This block fetches the stack pointer and stack segment selector that a processor loads when it enters a more privileged level. It is given the target level and the cached task register state: base address, limit, descriptor type, selector and a valid flag. From these it locates the per-level stack entry in the current task state segment and reads that entry through a word-wide request/acknowledge memory port. The entry's position and the limit check depend on which of the two task segment formats is in use.

Before any memory access, the block checks that the whole entry lies inside the segment limit. If the check fails, it raises an invalid-task-segment fault and reports the selector as the error code. A task register type that is neither format, or a cache marked invalid, is reported as an internal error. Each operation ends with a one-cycle `done` pulse. On success, the new selector and pointer appear on the result outputs in the cycle of that pulse. On a fault, the fault flag is raised together with the pulse.

Top module: `tsp_stack_fetch`

## Requirements
- R1: Type codes 1 and 3 select the 16-bit format and 9 and 11 select the 32-bit format. With any other type, or with `tr_valid` low, the block pulses `done` with `fault_int` high, sets `err_code` to 0 and makes no memory request.
- R2: In the 32-bit format the entry sits at E = base + 8*level + 4. The block reads the pointer's low word at E, its high word at E+2 and the selector at E+4.
- R3: In the 16-bit format the entry sits at E = base + 4*level + 2. The pointer is the word at E, zero-extended to 32 bits, and the selector is the word at E+2.
- R4: In the 32-bit format the block faults when 8*level + 4 + 7 exceeds the limit. It succeeds when that sum equals the limit.
- R5: In the 16-bit format the block faults when 4*level + 2 + 3 exceeds the limit. It succeeds when that sum equals the limit.
- R6: On a limit fault, `fault_tss` is high and `err_code` is `tr_sel` with bits 1:0 cleared.
- R7: A limit or type fault is reported with `done` one clock edge after the edge that samples `start`, and no memory request is made.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is sampled high. Each acknowledged read consumes one word from `mem_rdata`, and reads are made in ascending address order.
- R9: A successful `done` rises on the edge after the last acknowledged read. With acknowledges that take W wait cycles, the latency from the start edge is 1 + N*(W+1) edges, where N is 3 reads for the 32-bit format and 2 for the 16-bit format.
- R10: `done` is a single-cycle pulse. `fault_tss` and `fault_int` are high only together with `done`, and never both at once.
- R11: `sp_out` and `ss_sel` change only on a successful `done` and keep their values across faults.
- R12: A `start` pulse while an operation is in progress is ignored.
- R13: After reset, `done`, both faults, `mem_req`, `err_code`, `sp_out` and `ss_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch; sampled only when idle |
| priv_lvl | input | 2 | Target privilege level |
| tr_valid | input | 1 | Task register cache holds a valid descriptor |
| tr_type | input | 4 | Task register descriptor type code |
| tr_base | input | 32 | Task segment base address |
| tr_limit | input | 32 | Task segment limit (last valid byte offset) |
| tr_sel | input | 16 | Task register selector |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 16 | Read data word |
| done | output | 1 | Operation finished (one cycle) |
| fault_tss | output | 1 | Invalid-task-segment fault (limit check failed) |
| fault_int | output | 1 | Internal error: bad type or invalid cache |
| err_code | output | 16 | Fault error code |
| ss_sel | output | 16 | Fetched stack segment selector |
| sp_out | output | 32 | Fetched stack pointer |

## Verification
Faults are due exactly one edge after the start edge. Success is due 1 + N*(W+1) edges after the start edge, with the acknowledge delay W set by the bench's memory responder. For every operation the bench counts edges from the start edge and samples one time unit after each edge, so it checks the latency as well as the values. Read addresses are checked indirectly, because the responder returns a word derived from each address. The bench also counts request cycles during faulted operations and requires that count to be zero.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam logic [3:0] TYPE_T16_AVAIL = 4'd1;
  localparam logic [3:0] TYPE_T16_BUSY  = 4'd3;
  localparam logic [3:0] TYPE_T32_AVAIL = 4'd9;
  localparam logic [3:0] TYPE_T32_BUSY  = 4'd11;

  typedef enum logic [1:0] {FMT_BAD = 2'd0, FMT_16 = 2'd1, FMT_32 = 2'd2} tss_fmt_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CHECK = 2'd1, ST_READ = 2'd2} seq_state_e;
endpackage

// File: rtl/tsp_fmt_decode.sv
module tsp_fmt_decode
  import tsp_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] type_code,
  output tss_fmt_e   fmt
);
  always_comb begin
    fmt = FMT_BAD;
    if (valid) begin
      case (type_code)
        TYPE_T16_AVAIL, TYPE_T16_BUSY: fmt = FMT_16;
        TYPE_T32_AVAIL, TYPE_T32_BUSY: fmt = FMT_32;
        default:                       fmt = FMT_BAD;
      endcase
    end
  end
endmodule

// File: rtl/tsp_entry_calc.sv
module tsp_entry_calc
  import tsp_pkg::*;
#(
  parameter int LIMIT_W = 32,
  parameter int LVL_W   = 2
) (
  input  tss_fmt_e             fmt,
  input  logic [LVL_W-1:0]     level,
  input  logic [LIMIT_W-1:0]   limit,
  output logic [LIMIT_W-1:0]   offset,
  output logic [1:0]           last_idx,
  output logic                 limit_fail
);
  logic [LIMIT_W-1:0] lvl_ext;
  logic [LIMIT_W-1:0] top_byte;

  assign lvl_ext = LIMIT_W'(level);

  always_comb begin
    offset   = '0;
    top_byte = '0;
    last_idx = 2'd0;
    case (fmt)
      FMT_32: begin
        offset   = (lvl_ext << 3) + LIMIT_W'(4);
        top_byte = offset + LIMIT_W'(7);
        last_idx = 2'd2;
      end
      FMT_16: begin
        offset   = (lvl_ext << 2) + LIMIT_W'(2);
        top_byte = offset + LIMIT_W'(3);
        last_idx = 2'd1;
      end
      default: begin
        offset   = '0;
        top_byte = '0;
        last_idx = 2'd0;
      end
    endcase
  end

  assign limit_fail = (top_byte > limit);
endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl
  import tsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  tss_fmt_e          fmt,
  input  logic              limit_fail,
  input  logic [1:0]        last_idx,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic [SEL_W-1:0]  sel,
  input  logic              mem_ack,
  output logic              capture_en,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              word_we,
  output logic [1:0]        word_idx,
  output logic              commit,
  output logic              done,
  output logic              fault_tss,
  output logic              fault_int,
  output logic [SEL_W-1:0]  err_code
);
  seq_state_e       state_q, state_d;
  logic [1:0]       idx_q, idx_d;
  logic             done_q, done_d;
  logic             ftss_q, ftss_d;
  logic             fint_q, fint_d;
  logic [SEL_W-1:0] err_q, err_d;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    done_d     = 1'b0;
    ftss_d     = 1'b0;
    fint_d     = 1'b0;
    err_d      = err_q;
    capture_en = 1'b0;
    word_we    = 1'b0;
    commit     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          capture_en = 1'b1;
          state_d    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (fmt == FMT_BAD) begin
          done_d  = 1'b1;
          fint_d  = 1'b1;
          err_d   = '0;
          state_d = ST_IDLE;
        end else if (limit_fail) begin
          done_d  = 1'b1;
          ftss_d  = 1'b1;
          err_d   = {sel[SEL_W-1:2], 2'b00};
          state_d = ST_IDLE;
        end else begin
          idx_d   = 2'd0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          if (idx_q == last_idx) begin
            commit  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            word_we = 1'b1;
            idx_d   = 2'(idx_q + 2'd1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
      done_q  <= 1'b0;
      ftss_q  <= 1'b0;
      fint_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      ftss_q  <= ftss_d;
      fint_q  <= fint_d;
      err_q   <= err_d;
    end
  end

  assign mem_req   = (state_q == ST_READ);
  assign mem_addr  = entry_addr + ADDR_W'({idx_q, 1'b0});
  assign word_idx  = idx_q;
  assign done      = done_q;
  assign fault_tss = ftss_q;
  assign fault_int = fint_q;
  assign err_code  = err_q;
endmodule

// File: rtl/tsp_result.sv
module tsp_result #(
  parameter int WORD_W = 16,
  parameter int STAGE_N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_we,
  input  logic [1:0]          word_idx,
  input  logic                commit,
  input  logic                is32,
  input  logic [WORD_W-1:0]   rdata,
  output logic [2*WORD_W-1:0] sp_out,
  output logic [WORD_W-1:0]   ss_sel
);
  logic [WORD_W-1:0] stage_q [STAGE_N];

  for (genvar g = 0; g < STAGE_N; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
      end else if (word_we && (word_idx == 2'(g))) begin
        stage_q[g] <= rdata;
      end
    end
  end

  logic [2*WORD_W-1:0] sp_d;
  assign sp_d = is32 ? {stage_q[1], stage_q[0]} : {{WORD_W{1'b0}}, stage_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_out <= '0;
      ss_sel <= '0;
    end else if (commit) begin
      sp_out <= sp_d;
      ss_sel <= rdata;
    end
  end
endmodule

// File: rtl/tsp_stack_fetch.sv
module tsp_stack_fetch
  import tsp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int WORD_W = 16,
  parameter int LVL_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LVL_W-1:0]    priv_lvl,
  input  logic                tr_valid,
  input  logic [3:0]          tr_type,
  input  logic [ADDR_W-1:0]   tr_base,
  input  logic [ADDR_W-1:0]   tr_limit,
  input  logic [SEL_W-1:0]    tr_sel,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                done,
  output logic                fault_tss,
  output logic                fault_int,
  output logic [SEL_W-1:0]    err_code,
  output logic [SEL_W-1:0]    ss_sel,
  output logic [2*WORD_W-1:0] sp_out
);
  logic              capture_en;
  logic [LVL_W-1:0]  lvl_q;
  logic              valid_q;
  logic [3:0]        type_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      valid_q <= 1'b0;
      type_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
      sel_q   <= '0;
    end else if (capture_en) begin
      lvl_q   <= priv_lvl;
      valid_q <= tr_valid;
      type_q  <= tr_type;
      base_q  <= tr_base;
      limit_q <= tr_limit;
      sel_q   <= tr_sel;
    end
  end

  tss_fmt_e          fmt;
  logic [ADDR_W-1:0] offset;
  logic [1:0]        last_idx;
  logic              limit_fail;
  logic [ADDR_W-1:0] entry_addr;
  logic              word_we;
  logic [1:0]        word_idx;
  logic              commit;

  tsp_fmt_decode u_dec (
    .valid     (valid_q),
    .type_code (type_q),
    .fmt       (fmt)
  );

  tsp_entry_calc #(.LIMIT_W(ADDR_W), .LVL_W(LVL_W)) u_calc (
    .fmt        (fmt),
    .level      (lvl_q),
    .limit      (limit_q),
    .offset     (offset),
    .last_idx   (last_idx),
    .limit_fail (limit_fail)
  );

  assign entry_addr = base_q + offset;

  tsp_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fmt        (fmt),
    .limit_fail (limit_fail),
    .last_idx   (last_idx),
    .entry_addr (entry_addr),
    .sel        (sel_q),
    .mem_ack    (mem_ack),
    .capture_en (capture_en),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .word_we    (word_we),
    .word_idx   (word_idx),
    .commit     (commit),
    .done       (done),
    .fault_tss  (fault_tss),
    .fault_int  (fault_int),
    .err_code   (err_code)
  );

  tsp_result #(.WORD_W(WORD_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_we  (word_we),
    .word_idx (word_idx),
    .commit   (commit),
    .is32     (fmt == FMT_32),
    .rdata    (mem_rdata),
    .sp_out   (sp_out),
    .ss_sel   (ss_sel)
  );
endmodule

// File: rtl/tsp_sva.sv
module tsp_sva #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 16,
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_req,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_ack,
  input logic                done,
  input logic                fault_tss,
  input logic                fault_int,
  input logic [SEL_W-1:0]    err_code,
  input logic [SEL_W-1:0]    ss_sel,
  input logic [2*WORD_W-1:0] sp_out
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_tss || fault_int) |-> done);
  // R10
  single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_tss, fault_int}));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(sp_out) && $stable(ss_sel)));
  // R6
  err_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_tss |-> (err_code[1:0] == 2'b00));
  // R7
  fault_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_tss || fault_int) |-> !mem_req);
  // R9
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault_tss && !fault_int) |-> $past(mem_req && mem_ack));
endmodule

bind tsp_stack_fetch tsp_sva #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .done      (done),
  .fault_tss (fault_tss),
  .fault_int (fault_int),
  .err_code  (err_code),
  .ss_sel    (ss_sel),
  .sp_out    (sp_out)
);

// File: tb/tb_tsp_stack_fetch.sv
module tb_tsp_stack_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic        tr_valid = 1'b0;
  logic [3:0]  tr_type = '0;
  logic [31:0] tr_base = '0;
  logic [31:0] tr_limit = '0;
  logic [15:0] tr_sel = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done, fault_tss, fault_int;
  logic [15:0] err_code, ss_sel;
  logic [31:0] sp_out;

  int n_run = 0;
  int n_fail = 0;
  int wait_cfg = 0;
  int wcnt = 0;
  int lat, req_cyc;

  always #4 clk = ~clk;

  tsp_stack_fetch dut (
    .clk(clk), .rst_n(rst_n), .start(start), .priv_lvl(priv_lvl),
    .tr_valid(tr_valid), .tr_type(tr_type), .tr_base(tr_base),
    .tr_limit(tr_limit), .tr_sel(tr_sel), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault_tss(fault_tss), .fault_int(fault_int),
    .err_code(err_code), .ss_sel(ss_sel), .sp_out(sp_out)
  );

  function automatic logic [15:0] memf(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], a[31:24]};
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == wait_cfg) begin
        mem_ack   <= 1'b1;
        mem_rdata <= memf(mem_addr);
        wcnt      <= 0;
      end else begin
        mem_ack <= 1'b0;
        wcnt    <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic v, input logic [3:0] ty, input logic [1:0] lv,
                        input logic [31:0] base, input logic [31:0] lim,
                        input logic [15:0] sel, input int w);
    @(negedge clk);
    tr_valid = v; tr_type = ty; priv_lvl = lv; tr_base = base;
    tr_limit = lim; tr_sel = sel; wait_cfg = w; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0; req_cyc = 0;
    while (!done && lat < 500) begin
      @(posedge clk); #1;
      lat++;
      if (mem_req) req_cyc++;
    end
  endtask

  task automatic check32(input logic [3:0] ty, input logic [1:0] lv, input logic [31:0] base, input int w);
    logic [31:0] e;
    e = base + 32'd8 * lv + 32'd4;
    run_op(1'b1, ty, lv, base, 32'hFFFF, 16'h0013, w);
    chk("R2 sp32", sp_out, {memf(e + 32'd2), memf(e)});
    chk("R2 ss32", {16'h0, ss_sel}, {16'h0, memf(e + 32'd4)});
    chk("R9 latency32", lat, 1 + 3 * (w + 1));
    chk("R10 no fault on success", {30'h0, fault_tss, fault_int}, 32'h0);
  endtask

  task automatic check16(input logic [3:0] ty, input logic [1:0] lv, input logic [31:0] base, input int w);
    logic [31:0] e;
    e = base + 32'd4 * lv + 32'd2;
    run_op(1'b1, ty, lv, base, 32'hFFFF, 16'h0021, w);
    chk("R3 sp16 zero-extended", sp_out, {16'h0, memf(e)});
    chk("R3 ss16", {16'h0, ss_sel}, {16'h0, memf(e + 32'd2)});
    chk("R9 latency16", lat, 1 + 2 * (w + 1));
  endtask

  task automatic t_reset;
    chk("R13 reset done", {31'h0, done}, 32'h0);
    chk("R13 reset faults", {30'h0, fault_tss, fault_int}, 32'h0);
    chk("R13 reset req", {31'h0, mem_req}, 32'h0);
    chk("R13 reset err", {16'h0, err_code}, 32'h0);
    chk("R13 reset sp", sp_out, 32'h0);
    chk("R13 reset ss", {16'h0, ss_sel}, 32'h0);
  endtask

  task automatic t_formats;
    for (int l = 0; l < 3; l++) check32(4'd9, 2'(l), 32'h0004_1000, 0);
    check32(4'd11, 2'd1, 32'h0000_FFF0, 0);
    check16(4'd3, 2'd1, 32'h0002_0100, 0);
    check16(4'd1, 2'd0, 32'h0007_7770, 0);
    check16(4'd1, 2'd2, 32'h0003_0000, 1);
  endtask

  task automatic t_wait;
    check32(4'd11, 2'd2, 32'h0005_0000, 2);
  endtask

  task automatic t_limits;
    logic [31:0] sp_keep, e;
    // R4 boundary: level 2, 32-bit, top byte 27
    e = 32'h0001_0000 + 32'd20;
    run_op(1'b1, 4'd9, 2'd2, 32'h0001_0000, 32'd27, 16'h004B, 0);
    chk("R4 limit equal passes", {31'h0, fault_tss}, 32'h0);
    chk("R4 limit equal value", sp_out, {memf(e + 32'd2), memf(e)});
    sp_keep = sp_out;
    run_op(1'b1, 4'd9, 2'd2, 32'h0001_0000, 32'd26, 16'h004B, 0);
    chk("R4 limit exceeded faults", {31'h0, fault_tss}, 32'h1);
    chk("R6 err code", {16'h0, err_code}, 32'h0048);
    chk("R7 fault latency", lat, 1);
    chk("R7 no request on fault", req_cyc, 0);
    chk("R11 sp held over fault", sp_out, sp_keep);
    @(posedge clk); #1;
    chk("R10 done single pulse", {31'h0, done}, 32'h0);
    // R5 boundary: level 2, 16-bit, top byte 13
    run_op(1'b1, 4'd3, 2'd2, 32'h0002_0000, 32'd13, 16'h00A7, 0);
    chk("R5 limit equal passes", {31'h0, fault_tss}, 32'h0);
    chk("R5 limit equal value", sp_out, {16'h0, memf(32'h0002_000A)});
    run_op(1'b1, 4'd3, 2'd2, 32'h0002_0000, 32'd12, 16'h00A7, 0);
    chk("R5 limit exceeded faults", {31'h0, fault_tss}, 32'h1);
    chk("R6 err code 16", {16'h0, err_code}, 32'h00A4);
    chk("R7 no request 16", req_cyc, 0);
  endtask

  task automatic t_badtype;
    logic [31:0] sp_keep;
    logic [15:0] ss_keep;
    sp_keep = sp_out; ss_keep = ss_sel;
    run_op(1'b1, 4'd2, 2'd0, 32'h0001_0000, 32'hFFFF, 16'h0033, 0);
    chk("R1 bad type internal fault", {30'h0, fault_tss, fault_int}, 32'h1);
    chk("R1 bad type err zero", {16'h0, err_code}, 32'h0);
    chk("R1 bad type no request", req_cyc, 0);
    chk("R7 internal fault latency", lat, 1);
    run_op(1'b0, 4'd9, 2'd0, 32'h0001_0000, 32'hFFFF, 16'h0033, 0);
    chk("R1 invalid cache internal fault", {30'h0, fault_tss, fault_int}, 32'h1);
    chk("R1 invalid cache no request", req_cyc, 0);
    chk("R11 sp held over internal fault", sp_out, sp_keep);
    chk("R11 ss held over internal fault", {16'h0, ss_sel}, {16'h0, ss_keep});
  endtask

  task automatic t_busy_start;
    logic [31:0] e;
    e = 32'h0006_0000 + 32'd4;
    @(negedge clk);
    tr_valid = 1'b1; tr_type = 4'd9; priv_lvl = 2'd0; tr_base = 32'h0006_0000;
    tr_limit = 32'hFFFF; tr_sel = 16'h0010; wait_cfg = 1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    @(negedge clk);
    tr_type = 4'd1; priv_lvl = 2'd2; tr_base = 32'h0009_0000; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; lat++;
    while (!done && lat < 500) begin
      @(posedge clk); #1;
      lat++;
    end
    chk("R12 start while busy ignored sp", sp_out, {memf(e + 32'd2), memf(e)});
    chk("R12 start while busy latency", lat, 7);
    repeat (3) @(posedge clk);
    #1;
    chk("R12 no second operation", {31'h0, done}, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_formats();
    t_wait();
    t_limits();
    t_badtype();
    t_busy_start();
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule